// File: doc/BRIEF.md
# Real-time clock with alarms

This block keeps time inside the system clock domain. A one-cycle enable pulse at 32768 Hz drives a prescaler that divides by 128 and produces a 256 Hz subsecond tick. Each tick advances an 8-bit subsecond count. When that count wraps, a 32-bit seconds count advances by one.

Two alarms sit on the running count. The first compares the seconds count against a 20-bit time-of-day value. The second is a subsecond countdown that reloads itself each time it fires. Software reaches the counts, both alarm values and a control word through a simple word-addressed register bus. The block drives an interrupt line, a wake-up line and a selectable square wave.

Changes to the run enable and to both alarm enables are staged. A control write first raises busy, and the staged values take effect only when busy clears. The run enable is also protected: it can change only when a write-protect release bit is already set.

Top module: `rtc_timekeeper`

## Requirements
- R1: The subsecond count advances by one on every 128th enable pulse while the clock runs. When it steps from 0xFF to 0x00, the seconds count advances by one. Software writes to the seconds count (word 0) and the subsecond count (word 1) load them directly.
- R2: Out of reset the control word (word 4) reads 0x00000008, with busy (bit 3) set. Busy clears by itself four clocks after reset is released, and the control word then reads 0.
- R3: A write to the run enable (bit 0) is ignored unless the write-protect release (bit 15) was already 1 before that write, and busy was 0.
- R4: A control write made while busy is 0 raises busy for exactly 4 clocks. The run enable, the time-of-day alarm enable (bit 1) and the subsecond alarm enable (bit 2) read back, and act, with their old values until busy clears. Bits 0 to 2 of a control write made while busy is 1 are ignored.
- R5: Ready (bit 4) is cleared by hardware on the enable pulse just before each subsecond update, and set by the update itself. A control write with bit 4 at 0 clears it. Writing 1 to bit 4 has no effect.
- R6: With its enable active, the time-of-day flag (bit 6) sets on the tick where the seconds count changes to a value whose low 20 bits equal the alarm value (word 2, 20 bits wide).
- R7: With its enable active, the subsecond alarm counts ticks down from the reload value (word 3). For a reload value N ≥ 1, its flag (bit 7) sets on the Nth tick after the enable takes effect, and the count then reloads.
- R8: The interrupt output is high when the ready flag is set with the ready-interrupt enable (bit 5), or when an alarm flag is set with its enable. Each alarm flag is cleared once its enable is off.
- R9: The wake-up output is high whenever either alarm flag is set.
- R10: With the square-wave enable (bit 8) set, the select field (bits 10:9) picks the output. 0 gives 1 Hz, equal to bit 7 of the subsecond count. 1 gives 512 Hz, equal to bit 5 of the prescaler. 2 gives 4096 Hz, equal to bit 2 of the prescaler. Otherwise the output is 0.
- R11: The time-of-day alarm reads back only its low 20 bits, and the reload value reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_32k | input | 1 | One-cycle pulse at 32768 Hz |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request from either alarm |
| sqw | output | 1 | Square-wave output |

## Verification
Counting is checked with random seconds and subsecond start values and random run lengths. These runs tell a correct 0xFF wrap and carry apart from an off-by-one in the prescaler. Directed control sequences try enable writes with and without the write-protect release, and writes that land inside the busy window. These sequences separate staged behaviour from writes that take effect at once. The alarms are approached one tick at a time, which shows early firing apart from late firing. The square wave is compared against a bench model of the prescaler at random points for each select value.

// File: rtl/rtc_pkg.sv
// Package: shared types and register word addresses for the real-time clock.
// Assumes a word-addressed register bus with a 3-bit address.
package rtc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC = 3'd0,
        A_SUB = 3'd1,
        A_TOD = 3'd2,
        A_RLD = 3'd3,
        A_CTL = 3'd4
    } reg_addr_e;

    // Staged enables that only take effect when busy clears.
    typedef struct packed {
        logic sub_en;
        logic tod_en;
        logic run;
    } en_set_t;
endpackage

// File: rtl/rtc_prescaler.sv
// Module: divides the 32768 Hz enable pulse down to a subsecond tick.
// Assumes ce is a single-cycle pulse. The counter holds its value while run is low.
module rtc_prescaler #(
    parameter int DIV = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     ce,
    output logic                     tick,
    output logic                     pre_tick,
    output logic [$clog2(DIV)-1:0]   div_q
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);
    localparam logic [W-1:0] PRE  = W'(DIV - 2);

    // Prescale counter: advances on each enable pulse while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (run && ce)
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    // Tick on the last prescale step; pre-tick one pulse earlier.
    always_comb begin
        tick     = run && ce && (div_q == LAST);
        pre_tick = run && ce && (div_q == PRE);
    end
endmodule

// File: rtl/rtc_ctrl_reg.sv
// Module: control word storage with staged enables and a fixed busy window.
// Assumes wr is a single-cycle control write strobe. Busy starts set out of reset.
module rtc_ctrl_reg #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [31:0]          wdata,
    output rtc_pkg::en_set_t     eff,
    output logic                 busy,
    output logic                 rie,
    output logic                 sq_en,
    output logic [1:0]           fsel,
    output logic                 acre,
    output logic                 wen
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] START = CW'(BUSY_CYCLES - 1);

    rtc_pkg::en_set_t pend;
    logic [CW-1:0]    bcnt;

    // Plain configuration bits: written on any control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rie   <= 1'b0;
            sq_en <= 1'b0;
            fsel  <= 2'd0;
            acre  <= 1'b0;
            wen   <= 1'b0;
        end else if (wr) begin
            rie   <= wdata[5];
            sq_en <= wdata[8];
            fsel  <= wdata[10:9];
            acre  <= wdata[14];
            wen   <= wdata[15];
        end
    end

    // Staging: latch pending enables, run the busy window, then apply them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            eff  <= '0;
            busy <= 1'b1;
            bcnt <= START;
        end else if (wr && !busy) begin
            pend.tod_en <= wdata[1];
            pend.sub_en <= wdata[2];
            if (wen)
                pend.run <= wdata[0];
            busy <= 1'b1;
            bcnt <= START;
        end else if (busy) begin
            if (bcnt == '0) begin
                busy <= 1'b0;
                eff  <= pend;
            end else begin
                bcnt <= bcnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_counters.sv
// Module: subsecond and seconds counts, ready flag and both alarms.
// Assumes tick and pre_tick never coincide. A software count write wins over a tick in the same cycle.
module rtc_counters #(
    parameter int TOD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pre_tick,
    input  logic              tod_en,
    input  logic              sub_en,
    input  logic              wr_sec,
    input  logic              wr_sub,
    input  logic              wr_tod,
    input  logic              wr_rld,
    input  logic              clr_ready,
    input  logic [31:0]       wdata,
    output logic [31:0]       sec,
    output logic [7:0]        sub,
    output logic [TOD_W-1:0]  tod,
    output logic [31:0]       rld,
    output logic              ready,
    output logic              tod_fl,
    output logic              sub_fl
);
    logic        wrap;
    logic [31:0] sec_next;
    logic [31:0] down;

    // Wrap detection and next seconds value.
    always_comb begin
        wrap     = tick && (sub == 8'hFF);
        sec_next = sec + 32'd1;
    end

    // Subsecond count.
    always_ff @(posedge clk) begin
        if (!rst_n)      sub <= 8'h00;
        else if (wr_sub) sub <= wdata[7:0];
        else if (tick)   sub <= sub + 8'd1;
    end

    // Seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n)      sec <= 32'd0;
        else if (wr_sec) sec <= wdata;
        else if (wrap)   sec <= sec_next;
    end

    // Alarm value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod <= '0;
            rld <= 32'd0;
        end else begin
            if (wr_tod) tod <= wdata[TOD_W-1:0];
            if (wr_rld) rld <= wdata;
        end
    end

    // Ready flag: hardware clear before the update, set by it, software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         ready <= 1'b0;
        else if (pre_tick)  ready <= 1'b0;
        else if (tick)      ready <= 1'b1;
        else if (clr_ready) ready <= 1'b0;
    end

    // Time-of-day alarm flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !tod_en)
            tod_fl <= 1'b0;
        else if (wrap && !wr_sec && (sec_next[TOD_W-1:0] == tod))
            tod_fl <= 1'b1;
    end

    // Subsecond countdown alarm with reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down   <= 32'd0;
            sub_fl <= 1'b0;
        end else if (!sub_en) begin
            down   <= rld;
            sub_fl <= 1'b0;
        end else if (tick) begin
            if (down <= 32'd1) begin
                down   <= rld;
                sub_fl <= 1'b1;
            end else begin
                down <= down - 32'd1;
            end
        end
    end
endmodule

// File: rtl/rtc_timekeeper.sv
// Module: top of the real-time clock. It decodes the register bus, builds the read mux
// and combines the interrupt, wake-up and square-wave outputs.
// Assumes ce_32k is a one-cycle pulse in the clk domain. Reads are combinational.
module rtc_timekeeper #(
    parameter int DIV         = 128,
    parameter int BUSY_CYCLES = 4,
    parameter int TOD_W       = 20,
    parameter int TAP_FAST    = 2,
    parameter int TAP_MID     = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_32k,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        wake,
    output logic        sqw
);
    import rtc_pkg::*;
    localparam int DW = $clog2(DIV);

    en_set_t          eff;
    logic             busy, rie, sq_en, acre, wen;
    logic [1:0]       fsel;
    logic             tick, pre_tick;
    logic [DW-1:0]    div_q;
    logic [31:0]      sec, rld;
    logic [7:0]       sub;
    logic [TOD_W-1:0] tod;
    logic             ready, tod_fl, sub_fl;
    logic             wr_sec, wr_sub, wr_tod, wr_rld, wr_ctl;

    // Write decode.
    always_comb begin
        wr_sec = reg_wr && (reg_addr == A_SEC);
        wr_sub = reg_wr && (reg_addr == A_SUB);
        wr_tod = reg_wr && (reg_addr == A_TOD);
        wr_rld = reg_wr && (reg_addr == A_RLD);
        wr_ctl = reg_wr && (reg_addr == A_CTL);
    end

    rtc_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(eff.run), .ce(ce_32k),
        .tick(tick), .pre_tick(pre_tick), .div_q(div_q)
    );

    rtc_ctrl_reg #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(wr_ctl), .wdata(reg_wdata),
        .eff(eff), .busy(busy), .rie(rie), .sq_en(sq_en), .fsel(fsel),
        .acre(acre), .wen(wen)
    );

    rtc_counters #(.TOD_W(TOD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pre_tick(pre_tick),
        .tod_en(eff.tod_en), .sub_en(eff.sub_en),
        .wr_sec(wr_sec), .wr_sub(wr_sub), .wr_tod(wr_tod), .wr_rld(wr_rld),
        .clr_ready(wr_ctl && !reg_wdata[4]), .wdata(reg_wdata),
        .sec(sec), .sub(sub), .tod(tod), .rld(rld),
        .ready(ready), .tod_fl(tod_fl), .sub_fl(sub_fl)
    );

    // Read mux.
    always_comb begin
        case (reg_addr)
            A_SEC:   reg_rdata = sec;
            A_SUB:   reg_rdata = {24'd0, sub};
            A_TOD:   reg_rdata = 32'(tod);
            A_RLD:   reg_rdata = rld;
            A_CTL:   reg_rdata = {16'd0, wen, acre, 3'd0, fsel, sq_en, sub_fl, tod_fl,
                                  rie, ready, busy, eff.sub_en, eff.tod_en, eff.run};
            default: reg_rdata = 32'd0;
        endcase
    end

    // Interrupt and wake-up combination.
    always_comb begin
        irq  = (ready && rie) || (tod_fl && eff.tod_en) || (sub_fl && eff.sub_en);
        wake = tod_fl || sub_fl;
    end

    // Square-wave selection.
    always_comb begin
        sqw = 1'b0;
        if (sq_en) begin
            case (fsel)
                2'd0:    sqw = sub[7];
                2'd1:    sqw = div_q[TAP_MID];
                2'd2:    sqw = div_q[TAP_FAST];
                default: sqw = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_checker.sv
// Module: temporal checks on the real-time clock, bound to the top.
// Assumes signals are sampled on the rising clock edge and holds no state of its own.
module rtc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       pre_tick,
    input logic       busy,
    input logic       wr_ctl,
    input logic       run_eff,
    input logic       tod_en,
    input logic       sub_en,
    input logic [7:0] sub,
    input logic [31:0] sec,
    input logic       wr_sec,
    input logic       wr_sub,
    input logic       ready,
    input logic       tod_fl,
    input logic       sub_fl,
    input logic       sq_en,
    input logic       sqw
);
    p_sub_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_sub |=> sub == $past(sub) + 8'd1);
    p_sec_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick && sub == 8'hFF && !wr_sec |=> sec == $past(sec) + 32'd1);
    p_busy_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl && !busy |=> busy);
    p_hold_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(run_eff));
    p_ready_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |=> !ready);
    p_ready_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ready);
    p_tod_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tod_en |=> !tod_fl);
    p_sub_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_en |=> !sub_fl);
    p_sqw_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_en |-> !sqw);
endmodule

bind rtc_timekeeper rtc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pre_tick(pre_tick), .busy(busy),
    .wr_ctl(wr_ctl), .run_eff(eff.run), .tod_en(eff.tod_en), .sub_en(eff.sub_en),
    .sub(sub), .sec(sec), .wr_sec(wr_sec), .wr_sub(wr_sub), .ready(ready),
    .tod_fl(tod_fl), .sub_fl(sub_fl), .sq_en(sq_en), .sqw(sqw)
);

// File: tb/sim_rtc_timekeeper.sv
// Bench: random count runs plus directed control, alarm and square-wave cases,
// all checked against a bench model of the prescaler and counts.
module sim_rtc_timekeeper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_32k = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, wake, sqw;

    int n_run = 0;
    int n_bad = 0;

    logic [6:0]  m_div = 7'd0;
    logic [7:0]  m_ss  = 8'd0;
    logic [31:0] m_sec = 32'd0;
    logic        m_ready = 1'b0;
    logic        m_run = 1'b0;

    always #2.5 clk = ~clk;

    rtc_timekeeper u0 (
        .clk(clk), .rst_n(rst_n), .ce_32k(ce_32k), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .wake(wake), .sqw(sqw)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 3'd0) m_sec = d;
        if (a == 3'd1) m_ss = d[7:0];
        if (a == 3'd4 && !d[4]) m_ready = 1'b0;
    endtask

    task automatic ctl(input logic [31:0] d);
        wr(3'd4, d);
        repeat (5) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // Enable pulses, with the bench model stepped on each one.
    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ce_32k = 1'b1;
            @(posedge clk);
            if (m_run) begin
                if (m_div == 7'd126) m_ready = 1'b0;
                if (m_div == 7'd127) begin
                    if (m_ss == 8'hFF) m_sec = m_sec + 32'd1;
                    m_ss = m_ss + 8'd1;
                    m_ready = 1'b1;
                end
                m_div = m_div + 7'd1;
            end
        end
        @(negedge clk);
        ce_32k = 1'b0;
    endtask

    task automatic ticks(input int k);
        for (int t = 0; t < k; t++) begin
            logic [7:0] s0;
            s0 = m_ss;
            while (m_ss == s0) pulse(1);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_bad++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1D5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd4, v); check("R2 reset control", v, 32'h8);
        repeat (5) @(negedge clk);
        rd(3'd4, v); check("R2 busy self-clears", v, 32'h0);

        ctl(32'h0000_0001);
        rd(3'd4, v); check("R3 protected enable ignored", v & 32'h1, 32'h0);
        ctl(32'h0000_8000);
        wr(3'd4, 32'h0000_8001);
        rd(3'd4, v); check("R4 busy during staging", v & 32'h9, 32'h8);
        wr(3'd4, 32'h0000_8000);
        repeat (5) @(negedge clk);
        m_run = 1'b1;
        rd(3'd4, v); check("R4 R3 applied, write in busy ignored", v & 32'h9, 32'h1);

        for (int it = 0; it < 8; it++) begin
            wr(3'd0, $urandom);
            wr(3'd1, 32'($urandom_range(0, 255)));
            if (it == 0) begin wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hF0); end
            pulse($urandom_range(1, 700));
            rd(3'd0, v); check("R1 seconds", v, m_sec);
            rd(3'd1, v); check("R1 subseconds", v, {24'd0, m_ss});
            rd(3'd4, v); check("R5 ready tracking", (v >> 4) & 32'h1, {31'd0, m_ready});
        end

        ticks(1);
        rd(3'd4, v); check("R5 ready after update", (v >> 4) & 32'h1, 32'h1);
        ctl(32'h0000_8021);
        rd(3'd4, v); check("R5 software clear", (v >> 4) & 32'h1, 32'h0);
        check("R8 irq idle", {31'd0, irq}, 32'h0);
        ticks(1);
        check("R8 irq from ready", {31'd0, irq}, 32'h1);
        ctl(32'h0000_8001);
        check("R8 irq after ready clear", {31'd0, irq}, 32'h0);

        wr(3'd2, 32'h0001_2345);
        wr(3'd0, 32'hABC1_2344);
        wr(3'd1, 32'hFE);
        ctl(32'h0000_8003);
        ticks(1);
        rd(3'd4, v); check("R6 no early time alarm", (v >> 6) & 32'h1, 32'h0);
        ticks(1);
        rd(3'd4, v); check("R6 time alarm flag", (v >> 6) & 32'h1, 32'h1);
        check("R9 wake from time alarm", {31'd0, wake}, 32'h1);
        check("R8 irq from time alarm", {31'd0, irq}, 32'h1);
        ctl(32'h0000_8001);
        rd(3'd4, v); check("R8 time flag cleared", (v >> 6) & 32'h1, 32'h0);
        check("R9 wake cleared", {31'd0, wake}, 32'h0);

        wr(3'd3, 32'd3);
        ctl(32'h0000_8005);
        ticks(2);
        rd(3'd4, v); check("R7 no early subsecond alarm", (v >> 7) & 32'h1, 32'h0);
        ticks(1);
        rd(3'd4, v); check("R7 subsecond alarm flag", (v >> 7) & 32'h1, 32'h1);
        check("R9 wake from subsecond alarm", {31'd0, wake}, 32'h1);
        ctl(32'h0000_8001);
        rd(3'd4, v); check("R8 subsecond flag cleared", (v >> 7) & 32'h1, 32'h0);

        ctl(32'h0000_8501);
        for (int i = 0; i < 12; i++) begin
            pulse($urandom_range(1, 9));
            check("R10 4096 Hz", {31'd0, sqw}, {31'd0, m_div[2]});
        end
        ctl(32'h0000_8301);
        for (int i = 0; i < 12; i++) begin
            pulse($urandom_range(1, 40));
            check("R10 512 Hz", {31'd0, sqw}, {31'd0, m_div[5]});
        end
        ctl(32'h0000_8101);
        for (int i = 0; i < 4; i++) begin
            pulse($urandom_range(100, 3000));
            check("R10 1 Hz", {31'd0, sqw}, {31'd0, m_ss[7]});
        end
        ctl(32'h0000_8401);
        for (int i = 0; i < 6; i++) begin
            pulse($urandom_range(1, 9));
            check("R10 output off", {31'd0, sqw}, 32'h0);
        end

        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R11 alarm width", v, 32'h000F_FFFF);
        wr(3'd3, 32'hA5A5_5A5A);
        rd(3'd3, v); check("R11 reload readback", v, 32'hA5A5_5A5A);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule